// File: doc/BRIEF.md
# Program-Counter Address Match Interrupt Unit

This peripheral watches the processor's 20-bit program counter and raises an interrupt request when an instruction fetch lands on one of two programmable addresses. Each channel holds its own match address and its own enable bit. The request path never passes through the global interrupt mask or the priority-level logic. The channels therefore act as unmaskable breakpoints that software can arm and disarm one by one.

Software programs the unit through a byte-wide register port. One byte holds the channel enables. Each channel has a three-byte address register, laid out least significant byte first. The core presents the program counter together with a fetch-valid strobe. The unit answers one cycle later with a single-cycle request pulse and the number of the channel that matched.

Top module: `pam_unit`

## Requirements
- R1: After reset both enable bits and both 20-bit match addresses are zero, every register byte reads 0, and `irq` is low.
- R2: The enable register is at byte offset 0x09. Bit 0 arms channel 0 and bit 1 arms channel 1 (1 = armed). Bits 7..2 ignore writes and read 0.
- R3: The channel 0 address is at offsets 0x10 (bits 7:0), 0x11 (bits 15:8) and 0x12 (bits 19:16). Channel 1 uses 0x14, 0x15 and 0x16 in the same order. A written byte reads back unchanged.
- R4: In the top byte of each address register only bits 3..0 are stored. Bits 7..4 ignore writes and read 0.
- R5: Offsets outside 0x09, 0x10–0x12 and 0x14–0x16 read 0, and a write to one of them changes no register.
- R6: In the cycle after `fetch_vld` is high with `pc` equal to the address of an armed channel, `irq` is high for exactly one cycle. Back-to-back matching fetches give back-to-back pulses.
- R7: There is no request when `fetch_vld` is low, when `pc` differs from the stored address, or when the channel's enable bit is 0.
- R8: `irq_ch` gives the number of the channel that matched. When both channels match in the same cycle, it reports 0.
- R9: A register write in the same cycle as a fetch does not affect that fetch's comparison. The new value applies from the next cycle.
- R10: Both ends of the address range match: 0x00000 and 0xFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wen | input | 1 | Register byte write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| pc | input | 20 | Program counter of the current fetch |
| fetch_vld | input | 1 | Instruction fetch valid |
| irq | output | 1 | Match request, one-cycle pulse |
| irq_ch | output | 1 | Channel number of the request |

## Verification
Fetches are tried in several forms:
- an exact hit;
- an address off by one in the low byte;
- a matching address with the strobe low;
- a hit on a disarmed channel.

Together these separate the equality test, the strobe qualification and the enable gating. Giving both channels the same address, and then disarming channel 0, shows whether the priority order and the channel number are right. Two further patterns test timing and decode:
- writes made in the same cycle as a matching fetch reveal whether old or new register contents are used;
- the extreme addresses 0x00000 and 0xFFFFF show whether all 20 bits are decoded.

// File: rtl/pam_pkg.sv
package pam_pkg;
  localparam int DW          = 8;
  localparam int ENA_OFS     = 'h09;
  localparam int ADR_BASE    = 'h10;
  localparam int ADR_STRIDE  = 4;

  function automatic int bytes_for(input int bits);
    return (bits + DW - 1) / DW;
  endfunction

  function automatic int top_bits(input int bits);
    return bits - DW * (bytes_for(bits) - 1);
  endfunction
endpackage

// File: rtl/pam_regs.sv
module pam_regs
  import pam_pkg::*;
#(
  parameter int PC_W = 20,
  parameter int NCH  = 2,
  parameter int AW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wen,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [NCH-1:0]  en,
  output logic [PC_W-1:0] match_addr [NCH]
);
  localparam int NB   = bytes_for(PC_W);
  localparam int TOPB = top_bits(PC_W);
  localparam logic [AW-1:0] ENA_A = AW'(ENA_OFS);

  function automatic logic [PC_W-1:0] put_lane(input logic [PC_W-1:0] cur,
                                               input int lane,
                                               input logic [DW-1:0] d);
    logic [PC_W-1:0] r;
    r = cur;
    for (int i = 0; i < PC_W; i++)
      if (i / DW == lane) r[i] = d[i % DW];
    return r;
  endfunction

  function automatic logic [DW-1:0] get_lane(input logic [PC_W-1:0] v,
                                             input int lane);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < PC_W; i++)
      if (i / DW == lane) r[i % DW] = v[i];
    return r;
  endfunction

  logic          ena_sel;
  logic [NCH-1:0] ch_sel;
  int            ch_lane [NCH];

  assign ena_sel = (addr == ENA_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                en <= '0;
    else if (wen && ena_sel)   en <= wdata[NCH-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] BASE = AW'(ADR_BASE + c * ADR_STRIDE);
    assign ch_sel[c]  = (addr >= BASE) && (addr < BASE + AW'(NB));
    assign ch_lane[c] = int'(addr - BASE);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  match_addr[c] <= '0;
      else if (wen && ch_sel[c])   match_addr[c] <= put_lane(match_addr[c], ch_lane[c], wdata);
    end

    // R4: upper bits of the top byte are never stored, so they read 0
    a_r4_top_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == BASE + AW'(NB - 1)) |-> ((rdata >> TOPB) == '0));

    // R5: writes elsewhere leave this channel's address alone
    a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wen && ch_sel[c])) |=> $stable(match_addr[c]));
  end

  always_comb begin
    rdata = '0;
    if (ena_sel) rdata[NCH-1:0] = en;
    for (int c = 0; c < NCH; c++)
      if (ch_sel[c]) rdata = get_lane(match_addr[c], ch_lane[c]);
  end

  // R2: unassigned enable bits always read 0
  a_r2_ena_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ena_sel |-> ((rdata >> NCH) == '0));

  // R5: enables change only on a write to their own offset
  a_r5_ena_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wen && ena_sel) |=> $stable(en));
endmodule

// File: rtl/pam_cmp.sv
module pam_cmp #(
  parameter int PC_W = 20
) (
  input  logic            arm,
  input  logic            fetch_vld,
  input  logic [PC_W-1:0] pc,
  input  logic [PC_W-1:0] target,
  output logic            hit
);
  function automatic logic same_addr(input logic [PC_W-1:0] a,
                                     input logic [PC_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  assign hit = arm && fetch_vld && same_addr(target, pc);

  // R7: a hit needs both the strobe and the enable
  always_comb begin
    a_r7_hit_qualified: assert (!hit || (arm && fetch_vld));
  end
endmodule

// File: rtl/pam_arb.sv
module pam_arb #(
  parameter int NCH  = 2,
  parameter int CH_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  hit,
  output logic            irq,
  output logic [CH_W-1:0] irq_ch
);
  logic [CH_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (hit[i]) pick = CH_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      irq_ch <= '0;
    end else begin
      irq    <= |hit;
      irq_ch <= pick;
    end
  end

  // R8: channel 0 wins whenever it hits
  a_r8_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |=> (irq && irq_ch == '0));

  // R6: every request traces back to a hit one cycle earlier
  a_r6_irq_from_hit: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|hit));

  // R7: no hit, no request
  a_r7_no_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|hit) |=> !irq);
endmodule

// File: rtl/pam_unit.sv
module pam_unit
  import pam_pkg::*;
#(
  parameter int PC_W = 20,
  parameter int NCH  = 2,
  parameter int AW   = 16,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wen,
  input  logic [AW-1:0]   reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic [PC_W-1:0] pc,
  input  logic            fetch_vld,
  output logic            irq,
  output logic [CH_W-1:0] irq_ch
);
  logic [NCH-1:0]  ch_en;
  logic [PC_W-1:0] ch_addr [NCH];
  logic [NCH-1:0]  ch_hit;

  pam_regs #(.PC_W(PC_W), .NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .en(ch_en), .match_addr(ch_addr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    pam_cmp #(.PC_W(PC_W)) u_cmp (
      .arm(ch_en[c]), .fetch_vld(fetch_vld), .pc(pc),
      .target(ch_addr[c]), .hit(ch_hit[c])
    );
  end

  pam_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .hit(ch_hit), .irq(irq), .irq_ch(irq_ch)
  );

  // R6: a request only follows a valid fetch
  a_r6_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(fetch_vld));

  // R6: one pulse per fetch, never held without a new fetch
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !fetch_vld) |=> !irq);
endmodule

// File: tb/tb_pam_unit.sv
module tb_pam_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [19:0] pc = '0;
  logic        fetch_vld = 1'b0;
  logic        irq;
  logic [0:0]  irq_ch;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pam_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pc(pc),
    .fetch_vld(fetch_vld), .irq(irq), .irq_ch(irq_ch)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic set_addr(input int ch, input logic [19:0] v);
    wr(16'h10 + 16'(4 * ch), v[7:0]);
    wr(16'h11 + 16'(4 * ch), v[15:8]);
    wr(16'h12 + 16'(4 * ch), {4'h0, v[19:16]});
  endtask

  task automatic fetch_chk(input string req, input logic [19:0] p, input logic v,
                           input logic exp_irq, input logic exp_ch);
    @(negedge clk);
    pc = p; fetch_vld = v;
    @(negedge clk);
    fetch_vld = 1'b0;
    #1 chk(req, irq, exp_irq);
    if (exp_irq) chk(req, irq_ch, exp_ch);
  endtask

  task automatic t_reset();
    rd_chk("R1 ena", 16'h09, 8'h00);
    for (int i = 0; i < 3; i++) begin
      rd_chk("R1 ch0", 16'h10 + 16'(i), 8'h00);
      rd_chk("R1 ch1", 16'h14 + 16'(i), 8'h00);
    end
    chk("R1 irq", irq, 1'b0);
  endtask

  task automatic t_regs();
    wr(16'h09, 8'hFF);
    rd_chk("R2 ena upper bits", 16'h09, 8'h03);
    wr(16'h09, 8'h00);
    rd_chk("R2 ena clear", 16'h09, 8'h00);
    wr(16'h10, 8'h45); wr(16'h11, 8'h23); wr(16'h12, 8'hF1);
    rd_chk("R3 ch0 b0", 16'h10, 8'h45);
    rd_chk("R3 ch0 b1", 16'h11, 8'h23);
    rd_chk("R4 ch0 top", 16'h12, 8'h01);
    wr(16'h14, 8'hAB); wr(16'h15, 8'hCD); wr(16'h16, 8'h9E);
    rd_chk("R3 ch1 b0", 16'h14, 8'hAB);
    rd_chk("R3 ch1 b1", 16'h15, 8'hCD);
    rd_chk("R4 ch1 top", 16'h16, 8'h0E);
  endtask

  task automatic t_unmapped();
    wr(16'h13, 8'hFF); wr(16'h17, 8'hFF); wr(16'h0A, 8'hFF); wr(16'h08, 8'hFF);
    rd_chk("R5 0x13", 16'h13, 8'h00);
    rd_chk("R5 0x0A", 16'h0A, 8'h00);
    rd_chk("R5 0x18", 16'h18, 8'h00);
    rd_chk("R5 ena kept", 16'h09, 8'h00);
    rd_chk("R5 ch0 top kept", 16'h12, 8'h01);
    rd_chk("R5 ch1 top kept", 16'h16, 8'h0E);
  endtask

  task automatic t_match();
    wr(16'h09, 8'h01);
    fetch_chk("R6 ch0 hit", 20'h12345, 1'b1, 1'b1, 1'b0);
    fetch_chk("R7 off by one", 20'h12346, 1'b1, 1'b0, 1'b0);
    fetch_chk("R7 no strobe", 20'h12345, 1'b0, 1'b0, 1'b0);
    fetch_chk("R7 ch1 disarmed", 20'hECDAB, 1'b1, 1'b0, 1'b0);
    wr(16'h09, 8'h02);
    fetch_chk("R8 ch1 alone", 20'hECDAB, 1'b1, 1'b1, 1'b1);
    fetch_chk("R7 ch0 disarmed", 20'h12345, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_both();
    set_addr(1, 20'h12345);
    wr(16'h09, 8'h03);
    fetch_chk("R8 both match", 20'h12345, 1'b1, 1'b1, 1'b0);
    wr(16'h09, 8'h02);
    fetch_chk("R8 ch1 after ch0 off", 20'h12345, 1'b1, 1'b1, 1'b1);
    set_addr(1, 20'hECDAB);
  endtask

  task automatic t_back2back();
    wr(16'h09, 8'h01);
    @(negedge clk);
    pc = 20'h12345; fetch_vld = 1'b1;
    @(negedge clk);
    #1 chk("R6 pulse 1", irq, 1'b1);
    @(negedge clk);
    fetch_vld = 1'b0;
    #1 chk("R6 pulse 2", irq, 1'b1);
    @(negedge clk);
    #1 chk("R6 pulse ends", irq, 1'b0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    reg_addr = 16'h10; reg_wdata = 8'h99; reg_wen = 1'b1;
    pc = 20'h12345; fetch_vld = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; fetch_vld = 1'b0;
    #1 chk("R9 old addr used", irq, 1'b1);
    fetch_chk("R9 new addr hit", 20'h12399, 1'b1, 1'b1, 1'b0);
    fetch_chk("R9 old addr gone", 20'h12345, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    reg_addr = 16'h09; reg_wdata = 8'h00; reg_wen = 1'b1;
    pc = 20'h12399; fetch_vld = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; fetch_vld = 1'b0;
    #1 chk("R9 old enable used", irq, 1'b1);
    fetch_chk("R9 disable applied", 20'h12399, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_bounds();
    set_addr(0, 20'hFFFFF);
    wr(16'h09, 8'h01);
    fetch_chk("R10 top addr", 20'hFFFFF, 1'b1, 1'b1, 1'b0);
    fetch_chk("R10 near top", 20'h7FFFF, 1'b1, 1'b0, 1'b0);
    set_addr(0, 20'h00000);
    fetch_chk("R10 zero addr", 20'h00000, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1 irq in reset", irq, 1'b0);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_unmapped();
    t_match();
    t_both();
    t_back2back();
    t_same_cycle();
    t_bounds();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule